// File: doc/BRIEF.md
# Posted Write Bus Replayer

This block is the requesting side of a bridge on its downstream bus. It reads bursts that an upstream port has already accepted into a posted write queue and plays each one back as a memory write transaction on the downstream bus. It asks for the bus as soon as a burst's header is at the head of the queue, even if the data for that burst is still arriving.

The queue is read as a show-ahead FIFO. The head entry is visible all the time, and `fifo_rd` removes it at the next rising clock edge. An entry is either a header, which carries the start address in its data field, or a data word, which carries byte enables and a flag that marks the final word of the burst. The block waits for a grant and an idle bus before it starts. While the queue runs dry in the middle of a burst, it inserts wait states. When the target retries or disconnects, it resumes the burst at the correct address. When no target claims the transaction, it abandons the burst.

Bus signals are active low. Each signal is given as the value the block drives plus one shared drive enable (`mst_oe`). The wired bus values for FRAME and IRDY come back in as inputs, so the block can see whether the bus is idle.

Top module: `posted_write_replayer`

## Requirements
- R1: While `rst_n` is low and in the cycle after it is released, `req_n` is 1, `mst_oe` is 0, `fifo_rd` is 0 and `abort_err` is 0.
- R2: When the block is idle and a header entry (`fifo_hdr`=1) is at the head of a non-empty queue, `fifo_rd` pulses for one cycle to take the header. `req_n` is 0 from the next cycle on, whether or not any data word of that burst is queued yet.
- R3: The address phase begins only in the cycle after an edge at which `gnt_n`=0, `frame_n_i`=1 and `irdy_n_i`=1. In that cycle the block drives `mst_oe`=1, `frame_n_o`=0, `irdy_n_o`=1, `ad_o` = the stored address with bits [1:0] forced to 00, and `cbe_n_o`=4'b0111 (memory write).
- R4: In a data phase, `ad_o` and `cbe_n_o` carry the head data word and its byte enables. A data word leaves the queue only at an edge where `irdy_n_o`=0 and `trdy_n_i`=0. Each transferred word belongs to an address 4 bytes above the previous one.
- R5: If the queue has no data word at its head and the final word has not yet been sent, the block keeps `frame_n_o`=0 and drives `irdy_n_o`=1 (a wait state) until data arrives. The burst is not ended.
- R6: `frame_n_o` is 1 together with `irdy_n_o`=0 only while the head word has `fifo_last`=1. After that word transfers, the block drives FRAME and IRDY high for one cycle, then turns off `mst_oe`, releases `req_n` and returns to idle.
- R7: `stop_n_i`=0 seen with `irdy_n_o`=0 ends the transaction. The word is consumed if `trdy_n_i` was also 0 (disconnect) and kept if not (retry). If words remain, the block releases the bus for one cycle, asserts `req_n` again, and resumes with an address phase at the base address plus 4 times the number of words already transferred.
- R8: If `devsel_n_i` has not been 0 at any of the first 5 edges after the address phase (parameter `DEVSEL_TMO`), the block pulses `abort_err` for one cycle with FRAME and IRDY high. It then turns off `mst_oe` and keeps `req_n` high. It discards the burst's remaining data words up to and including the one with `fifo_last`=1, and then serves the next header normally.
- R9: A `devsel_n_i` of 0 at exactly the 5th edge after the address phase is accepted, and the burst completes without `abort_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_empty | input | 1 | Queue holds no entry |
| fifo_hdr | input | 1 | Head entry is a header (address) rather than data |
| fifo_last | input | 1 | Head data word is the final one of its burst |
| fifo_data | input | DW (32) | Head entry payload: address for a header, write data otherwise |
| fifo_be_n | input | DW/8 (4) | Active-low byte enables of the head data word |
| fifo_rd | output | 1 | Remove the head entry at this clock edge |
| req_n | output | 1 | Bus request, active low |
| gnt_n | input | 1 | Bus grant, active low |
| frame_n_i | input | 1 | Wired FRAME value on the bus |
| irdy_n_i | input | 1 | Wired IRDY value on the bus |
| trdy_n_i | input | 1 | Target ready, active low |
| stop_n_i | input | 1 | Target stop, active low |
| devsel_n_i | input | 1 | Target claim, active low |
| mst_oe | output | 1 | Drive enable for FRAME, IRDY, AD and C/BE |
| frame_n_o | output | 1 | Driven FRAME value |
| irdy_n_o | output | 1 | Driven IRDY value |
| ad_o | output | DW (32) | Driven address / data |
| cbe_n_o | output | DW/8 (4) | Driven command / byte enables |
| abort_err | output | 1 | One-cycle pulse on a master abort |

## Verification
Burst length, target claim delay and target ready delay are swept together, so a wrong address step, a premature pop or a misplaced last phase shows up as a wrong word in the recorded bus log. A retry or a disconnect is placed on every word position of several burst lengths. This separates a resume address that counts the retried word from one that does not, and it shows when a disconnect on the final word wrongly re-requests the bus. A slowly filled queue, a withheld grant and a busy bus check the early request and the wait states. Claim delays at the timeout limit and one past it, with full and partly filled queues, check the abort boundary and that the discard stops at the burst's last word.

// File: rtl/pwr_pkg.sv
// Package: shared types and constants of the posted write replayer.
// Assumes a 4-bit bus command field in the low bits of C/BE.
package pwr_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_ADDR  = 3'd2,
        ST_DATA  = 3'd3,
        ST_END   = 3'd4,
        ST_ABORT = 3'd5,
        ST_DRAIN = 3'd6
    } pwr_state_e;

    // Memory write command code on C/BE during the address phase
    localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;

endpackage

// File: rtl/pwr_addr_ctr.sv
// Module: running burst address.
// Loads the header address with the low two bits cleared and steps one DWORD
// per transferred word, so it always names the next word to send.
// Assumes load and step never occur in the same cycle.
module pwr_addr_ctr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] DWORD_BYTES = AW'(4);
    localparam logic [AW-1:0] ALIGN_MASK  = ~(AW'(3));

    // Hold the address of the next word still to be transferred
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val & ALIGN_MASK;
        end else if (step) begin
            addr <= addr + DWORD_BYTES;
        end
    end
endmodule

// File: rtl/pwr_devsel_timer.sv
// Module: target claim watchdog.
// Re-armed on each address phase. It counts the edges of the data phase until
// the target claims, and flags a timeout at the TMO-th edge without a claim.
// Assumes watch is only high in the cycles after an arm.
module pwr_devsel_timer #(
    parameter int TMO = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic watch,
    input  logic devsel_n,
    output logic timeout
);
    localparam int CW = $clog2(TMO + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TMO - 1);

    logic [CW-1:0] cnt;
    logic          seen;

    // Count claim-less edges and remember a claim for the rest of the transaction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            seen <= 1'b0;
        end else if (arm) begin
            cnt  <= '0;
            seen <= 1'b0;
        end else if (watch && !seen) begin
            if (!devsel_n) begin
                seen <= 1'b1;
            end else if (cnt != LIMIT) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Timeout when the last allowed edge passes without a claim
    always_comb begin
        timeout = watch && !seen && devsel_n && (cnt == LIMIT);
    end
endmodule

// File: rtl/pwr_seq.sv
// Module: transaction sequencer.
// Takes headers, requests the bus, runs the address and data phases, handles
// stop and timeout, and drains abandoned bursts.
// Assumes a show-ahead queue whose head is stable until it is popped.
module pwr_seq
    import pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_empty,
    input  logic       fifo_hdr,
    input  logic       fifo_last,
    input  logic       gnt_n,
    input  logic       frame_n_i,
    input  logic       irdy_n_i,
    input  logic       trdy_n_i,
    input  logic       stop_n_i,
    input  logic       timeout,
    output pwr_state_e state,
    output logic       hdr_pop,
    output logic       xfer,
    output logic       fifo_rd,
    output logic       req_n,
    output logic       frame_n_o,
    output logic       irdy_n_o,
    output logic       mst_oe,
    output logic       arm,
    output logic       watch,
    output logic       abort_err
);
    pwr_state_e nxt;
    logic       resume;
    logic       avail;
    logic       hdr_head;
    logic       stop_seen;
    logic       done_last;

    // Classify the queue head and the target response of this cycle
    always_comb begin
        avail     = !fifo_empty && !fifo_hdr;
        hdr_head  = !fifo_empty && fifo_hdr;
        xfer      = (state == ST_DATA) && avail && !trdy_n_i;
        stop_seen = (state == ST_DATA) && avail && !stop_n_i;
        done_last = xfer && fifo_last;
        hdr_pop   = (state == ST_IDLE) && hdr_head;
    end

    // Next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (hdr_head) nxt = ST_REQ;
            ST_REQ:   if (!gnt_n && frame_n_i && irdy_n_i) nxt = ST_ADDR;
            ST_ADDR:  nxt = ST_DATA;
            ST_DATA: begin
                if (timeout)        nxt = ST_ABORT;
                else if (done_last) nxt = ST_END;
                else if (stop_seen) nxt = ST_END;
            end
            ST_END:   nxt = resume ? ST_REQ : ST_IDLE;
            ST_ABORT: nxt = ST_DRAIN;
            ST_DRAIN: if (avail && fifo_last) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register and the flag that says a stopped burst still has words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            resume <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_DATA && nxt == ST_END) begin
                resume <= !done_last;
            end
        end
    end

    // Bus and queue controls decoded from the state
    always_comb begin
        req_n     = !((state == ST_REQ) || (state == ST_ADDR));
        mst_oe    = (state == ST_ADDR) || (state == ST_DATA) ||
                    (state == ST_END)  || (state == ST_ABORT);
        frame_n_o = 1'b1;
        irdy_n_o  = 1'b1;
        if (state == ST_ADDR) begin
            frame_n_o = 1'b0;
        end else if (state == ST_DATA) begin
            irdy_n_o  = !avail;
            frame_n_o = avail && fifo_last;
        end
        fifo_rd   = hdr_pop || xfer || ((state == ST_DRAIN) && avail);
        arm       = (state == ST_ADDR);
        watch     = (state == ST_DATA);
        abort_err = (state == ST_ABORT);
    end
endmodule

// File: rtl/posted_write_replayer.sv
// Module: top of the posted write replayer.
// Ties the sequencer, the address counter and the claim watchdog together and
// muxes address or data onto AD and command or byte enables onto C/BE.
// Assumes DW is a multiple of 32 so C/BE is at least 4 bits wide.
module posted_write_replayer
    import pwr_pkg::*;
#(
    parameter int DW         = 32,
    parameter int DEVSEL_TMO = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    input  logic              fifo_hdr,
    input  logic              fifo_last,
    input  logic [DW-1:0]     fifo_data,
    input  logic [DW/8-1:0]   fifo_be_n,
    output logic              fifo_rd,
    output logic              req_n,
    input  logic              gnt_n,
    input  logic              frame_n_i,
    input  logic              irdy_n_i,
    input  logic              trdy_n_i,
    input  logic              stop_n_i,
    input  logic              devsel_n_i,
    output logic              mst_oe,
    output logic              frame_n_o,
    output logic              irdy_n_o,
    output logic [DW-1:0]     ad_o,
    output logic [DW/8-1:0]   cbe_n_o,
    output logic              abort_err
);
    localparam int BEW = DW / 8;
    localparam logic [BEW-1:0] CMD_FIELD = BEW'(CMD_MEM_WRITE);

    pwr_state_e      state;
    logic            hdr_pop;
    logic            xfer;
    logic            arm;
    logic            watch;
    logic            timeout;
    logic [DW-1:0]   addr;

    pwr_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .fifo_hdr   (fifo_hdr),
        .fifo_last  (fifo_last),
        .gnt_n      (gnt_n),
        .frame_n_i  (frame_n_i),
        .irdy_n_i   (irdy_n_i),
        .trdy_n_i   (trdy_n_i),
        .stop_n_i   (stop_n_i),
        .timeout    (timeout),
        .state      (state),
        .hdr_pop    (hdr_pop),
        .xfer       (xfer),
        .fifo_rd    (fifo_rd),
        .req_n      (req_n),
        .frame_n_o  (frame_n_o),
        .irdy_n_o   (irdy_n_o),
        .mst_oe     (mst_oe),
        .arm        (arm),
        .watch      (watch),
        .abort_err  (abort_err)
    );

    pwr_addr_ctr #(.AW(DW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hdr_pop),
        .load_val (fifo_data),
        .step     (xfer),
        .addr     (addr)
    );

    pwr_devsel_timer #(.TMO(DEVSEL_TMO)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .watch    (watch),
        .devsel_n (devsel_n_i),
        .timeout  (timeout)
    );

    // Address phase carries address and command, every other cycle the head word
    always_comb begin
        if (state == ST_ADDR) begin
            ad_o    = addr;
            cbe_n_o = CMD_FIELD;
        end else begin
            ad_o    = fifo_data;
            cbe_n_o = fifo_be_n;
        end
    end
endmodule

// File: rtl/pwr_checker.sv
// Module: protocol checker for the posted write replayer, attached by bind.
// Assumes the queue head stays stable while it is not popped.
module pwr_checker #(
    parameter int DW = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fifo_empty,
    input logic            fifo_hdr,
    input logic            fifo_last,
    input logic            fifo_rd,
    input logic            req_n,
    input logic            gnt_n,
    input logic            frame_n_i,
    input logic            irdy_n_i,
    input logic            trdy_n_i,
    input logic            stop_n_i,
    input logic            devsel_n_i,
    input logic            mst_oe,
    input logic            frame_n_o,
    input logic            irdy_n_o,
    input logic [DW-1:0]   ad_o,
    input logic [DW/8-1:0] cbe_n_o,
    input logic            abort_err
);
    // R2: a taken header leads to a request in the next cycle
    a_r2_req_after_header: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && fifo_hdr && !fifo_empty) |=> !req_n);

    // R3: driving starts only after grant on an idle bus, with an address phase
    a_r3_start_on_grant_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mst_oe) |-> (!frame_n_o && irdy_n_o &&
                           $past(!gnt_n && frame_n_i && irdy_n_i)));

    // R4: a data word leaves the queue only on a completed handshake
    a_r4_pop_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && !fifo_hdr && mst_oe) |-> (!irdy_n_o && !trdy_n_i));

    // R4: an offered word stays on the bus while the claimed target waits
    a_r4_hold_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_oe && !irdy_n_o && trdy_n_i && stop_n_i && !devsel_n_i)
        |=> (!irdy_n_o && $stable(ad_o) && $stable(cbe_n_o)));

    // R6: FRAME is released under IRDY only for the final word
    a_r6_frame_off_only_last: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_oe && frame_n_o && !irdy_n_o) |-> (fifo_last && !fifo_hdr));

    // R8: the abort flag is a single pulse followed by a released bus and no request
    a_r8_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        abort_err |=> (!abort_err && !mst_oe && req_n));
endmodule

bind posted_write_replayer pwr_checker #(.DW(DW)) u_pwr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_empty (fifo_empty),
    .fifo_hdr   (fifo_hdr),
    .fifo_last  (fifo_last),
    .fifo_rd    (fifo_rd),
    .req_n      (req_n),
    .gnt_n      (gnt_n),
    .frame_n_i  (frame_n_i),
    .irdy_n_i   (irdy_n_i),
    .trdy_n_i   (trdy_n_i),
    .stop_n_i   (stop_n_i),
    .devsel_n_i (devsel_n_i),
    .mst_oe     (mst_oe),
    .frame_n_o  (frame_n_o),
    .irdy_n_o   (irdy_n_o),
    .ad_o       (ad_o),
    .cbe_n_o    (cbe_n_o),
    .abort_err  (abort_err)
);

// File: tb/posted_write_replayer_tb_top.sv
// Bench: queue model, target model with programmable claim delay, ready delay
// and one stop event, and sweeps over burst shapes and target responses.
module posted_write_replayer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int TMO = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // queue model
    logic [31:0] q_data [0:63];
    logic [3:0]  q_be   [0:63];
    logic        q_hdr  [0:63];
    logic        q_last [0:63];
    logic [5:0]  wr_ptr = '0;
    logic [5:0]  rd_ptr;

    logic        fifo_empty, fifo_hdr, fifo_last, fifo_rd;
    logic [31:0] fifo_data;
    logic [3:0]  fifo_be_n;
    logic        req_n, gnt_n = 1'b0;
    logic        oth_frame = 1'b1, oth_irdy = 1'b1;
    logic        frame_bus, irdy_bus;
    logic        trdy_r, stop_r, devsel_r;
    logic        mst_oe, frame_n_o, irdy_n_o, abort_err;
    logic [31:0] ad_o;
    logic [3:0]  cbe_n_o;

    assign fifo_empty = (wr_ptr == rd_ptr);
    assign fifo_hdr   = q_hdr[rd_ptr];
    assign fifo_last  = q_last[rd_ptr];
    assign fifo_data  = q_data[rd_ptr];
    assign fifo_be_n  = q_be[rd_ptr];
    assign frame_bus  = mst_oe ? frame_n_o : oth_frame;
    assign irdy_bus   = mst_oe ? irdy_n_o : oth_irdy;

    always @(posedge clk) begin
        if (!rst_n) rd_ptr <= '0;
        else if (fifo_rd) rd_ptr <= rd_ptr + 1'b1;
    end

    posted_write_replayer #(.DW(DW), .DEVSEL_TMO(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_hdr(fifo_hdr),
        .fifo_last(fifo_last), .fifo_data(fifo_data), .fifo_be_n(fifo_be_n),
        .fifo_rd(fifo_rd), .req_n(req_n), .gnt_n(gnt_n), .frame_n_i(frame_bus),
        .irdy_n_i(irdy_bus), .trdy_n_i(trdy_r), .stop_n_i(stop_r),
        .devsel_n_i(devsel_r), .mst_oe(mst_oe), .frame_n_o(frame_n_o),
        .irdy_n_o(irdy_n_o), .ad_o(ad_o), .cbe_n_o(cbe_n_o), .abort_err(abort_err)
    );

    // target model settings, written by the stimulus
    int dsel_dly = 1, wait_n = 0, stop_at = -1, stop_base = 0;
    bit disc_mode = 1'b0;

    // target model state and logs, written only by the target process
    logic [31:0] lg_addr [0:1023];
    logic [31:0] lg_data [0:1023];
    logic [3:0]  lg_be   [0:1023];
    logic        lg_frame[0:1023];
    int lg_n = 0, aph_cnt = 0, stop_fired = 0, tcnt = 0, wc = 0;
    logic [31:0] aph_addr = '0, taddr = '0;
    logic [3:0]  aph_cmd = '0;
    bit t_act = 1'b0, t_end = 1'b0, xf, sv, dv, rdy, sh;

    // Target: records transfers and answers with claim, ready and stop
    always @(posedge clk) begin
        if (!rst_n) begin
            t_act = 1'b0; t_end = 1'b0;
            devsel_r <= 1'b1; trdy_r <= 1'b1; stop_r <= 1'b1;
        end else begin
            xf = mst_oe && !irdy_n_o && !trdy_r;
            sv = mst_oe && !irdy_n_o && !stop_r;
            if (xf) begin
                lg_addr[lg_n] = taddr; lg_data[lg_n] = ad_o;
                lg_be[lg_n] = cbe_n_o; lg_frame[lg_n] = frame_n_o;
                lg_n = lg_n + 1; taddr = taddr + 32'd4;
            end
            if (sv) stop_fired = stop_fired + 1;
            if (!t_act && mst_oe && !frame_n_o && irdy_n_o) begin
                t_act = 1'b1; t_end = 1'b0; taddr = ad_o; aph_cnt = aph_cnt + 1;
                aph_addr = ad_o; aph_cmd = cbe_n_o; tcnt = 1; wc = 0;
            end else if (t_act && frame_bus && irdy_bus) begin
                t_act = 1'b0;
            end
            if (!t_act || t_end || (xf && frame_n_o) || sv) begin
                if (t_act) t_end = 1'b1;
                devsel_r <= 1'b1; trdy_r <= 1'b1; stop_r <= 1'b1;
            end else begin
                if (xf) wc = 0; else if (!devsel_r) wc = wc + 1;
                dv  = (tcnt >= dsel_dly);
                rdy = dv && (wc >= wait_n);
                sh  = rdy && (lg_n == stop_at) && (stop_fired == stop_base);
                devsel_r <= !dv;
                trdy_r   <= !(rdy && (!sh || disc_mode));
                stop_r   <= !sh;
                tcnt = tcnt + 1;
            end
        end
    end

    // monitors: wait states and abort pulses
    int wait_cnt = 0, ab_cnt = 0;
    bit prev_oe = 1'b0;
    always @(posedge clk) begin
        if (mst_oe && prev_oe && !frame_n_o && irdy_n_o) wait_cnt = wait_cnt + 1;
        if (abort_err) ab_cnt = ab_cnt + 1;
        prev_oe = mst_oe;
    end

    int n_chk = 0, n_fail = 0;
    int log_base = 0, aph_base = 0, ab_base = 0, wait_base = 0;

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] dval(input logic [31:0] base, input int i);
        return base ^ (32'h5A00_0000 + 32'(i) * 32'h0001_0203);
    endfunction

    function automatic logic [3:0] bval(input int i);
        return 4'((i * 3 + 1) & 15);
    endfunction

    task automatic push(input bit hdr, input bit last, input logic [31:0] d,
                        input logic [3:0] be);
        q_hdr[wr_ptr] = hdr; q_last[wr_ptr] = last;
        q_data[wr_ptr] = d; q_be[wr_ptr] = be;
        wr_ptr = wr_ptr + 1'b1;
    endtask

    task automatic push_data(input logic [31:0] base, input int len, input int gap);
        for (int i = 0; i < len; i++) begin
            push(1'b0, i == len - 1, dval(base, i), bval(i));
            if (gap > 0) tick(gap);
        end
    endtask

    task automatic start();
        log_base = lg_n; aph_base = aph_cnt; ab_base = ab_cnt;
        wait_base = wait_cnt; stop_base = stop_fired; stop_at = -1;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        for (int c = 0; c < 400 && quiet < 3; c++) begin
            tick(1);
            if (fifo_empty && req_n && !mst_oe) quiet++; else quiet = 0;
        end
    endtask

    task automatic check_burst(input logic [31:0] base, input int len, input string tag);
        chk(lg_n - log_base == len, {tag, " word count"}, lg_n - log_base, len);
        for (int i = 0; i < len && i < lg_n - log_base; i++) begin
            chk(lg_addr[log_base + i] == base + 32'(4 * i), {tag, " R4 address"},
                lg_addr[log_base + i], base + 32'(4 * i));
            chk(lg_data[log_base + i] == dval(base, i), {tag, " R4 data"},
                lg_data[log_base + i], dval(base, i));
            chk(lg_be[log_base + i] == bval(i), {tag, " R4 byte enables"},
                32'(lg_be[log_base + i]), 32'(bval(i)));
            chk(lg_frame[log_base + i] == (i == len - 1), {tag, " R6 frame on last"},
                32'(lg_frame[log_base + i]), 32'(i == len - 1));
        end
        chk(req_n && !mst_oe && fifo_empty, {tag, " R6 released"},
            {req_n, mst_oe, fifo_empty}, 3'b101);
    endtask

    initial begin
        logic [31:0] base;
        for (int i = 0; i < 64; i++) begin
            q_data[i] = '0; q_be[i] = '0; q_hdr[i] = 1'b0; q_last[i] = 1'b0;
        end
        tick(3);
        chk(req_n && !mst_oe && !fifo_rd && !abort_err, "R1 reset values",
            {req_n, mst_oe, fifo_rd, abort_err}, 4'b1000);
        rst_n = 1'b1;
        tick(1);
        chk(req_n && !mst_oe && !fifo_rd && !abort_err, "R1 after release",
            {req_n, mst_oe, fifo_rd, abort_err}, 4'b1000);

        // R4/R6/R3: burst length x claim delay x ready delay
        for (int len = 1; len <= 4; len++)
            for (int d = 1; d <= 4; d++)
                for (int w = 0; w <= 1; w++) begin
                    base = 32'h1000_0000 + 32'(len * 256 + d * 16 + w * 4);
                    dsel_dly = d; wait_n = w; start();
                    push(1'b1, 1'b0, base | 32'h3, 4'h0);
                    push_data(base, len, 0);
                    wait_idle();
                    check_burst(base, len, "R4 sweep");
                    chk(aph_cnt - aph_base == 1, "R3 one address phase", aph_cnt - aph_base, 1);
                    chk(aph_addr == base && aph_cmd == 4'b0111, "R3 address and command",
                        {aph_addr[27:0], aph_cmd}, {base[27:0], 4'b0111});
                    chk(ab_cnt == ab_base, "R9 no abort", ab_cnt - ab_base, 0);
                end
        dsel_dly = 1; wait_n = 0;

        // R2: header alone triggers the request; grant withheld
        base = 32'h2000_0040; gnt_n = 1'b1; start();
        push(1'b1, 1'b0, base, 4'h0);
        tick(3);
        chk(!req_n && !mst_oe && fifo_empty, "R2 early request",
            {req_n, mst_oe, fifo_empty}, 3'b001);
        push_data(base, 2, 0);
        tick(3);
        chk(!mst_oe && !req_n, "R3 no start without grant", {mst_oe, req_n}, 2'b00);
        gnt_n = 1'b0;
        wait_idle();
        check_burst(base, 2, "R2 burst");

        // R3: grant present but bus busy
        base = 32'h2000_0100; oth_irdy = 1'b0; start();
        push(1'b1, 1'b0, base, 4'h0);
        push_data(base, 2, 0);
        tick(4);
        chk(!mst_oe && !req_n, "R3 no start on busy bus", {mst_oe, req_n}, 2'b00);
        oth_irdy = 1'b1;
        wait_idle();
        check_burst(base, 2, "R3 burst");

        // R5: slow queue fill inserts wait states
        base = 32'h3000_0200; start();
        push(1'b1, 1'b0, base, 4'h0);
        tick(2);
        push_data(base, 3, 3);
        wait_idle();
        check_burst(base, 3, "R5 burst");
        chk(wait_cnt - wait_base >= 3, "R5 wait states", wait_cnt - wait_base, 3);
        chk(ab_cnt == ab_base, "R5 no abort", ab_cnt - ab_base, 0);

        // R7: retry or disconnect at every word position
        for (int len = 2; len <= 4; len++)
            for (int k = 0; k < len; k++)
                for (int m = 0; m <= 1; m++) begin
                    base = 32'h4000_0000 + 32'(len * 512 + k * 32 + m * 8);
                    disc_mode = bit'(m); start(); stop_at = log_base + k;
                    push(1'b1, 1'b0, base, 4'h0);
                    push_data(base, len, 0);
                    wait_idle();
                    check_burst(base, len, "R7 stop");
                    chk(stop_fired - stop_base == 1, "R7 stop taken", stop_fired - stop_base, 1);
                    if (m == 1 && k == len - 1) begin
                        chk(aph_cnt - aph_base == 1, "R7 no resume after final disconnect",
                            aph_cnt - aph_base, 1);
                    end else begin
                        chk(aph_cnt - aph_base == 2, "R7 resumed", aph_cnt - aph_base, 2);
                        chk(aph_addr == base + 32'(4 * (k + m)), "R7 resume address",
                            aph_addr, base + 32'(4 * (k + m)));
                    end
                end
        disc_mode = 1'b0;

        // R9: claim at the last allowed edge
        base = 32'h5000_0000; dsel_dly = TMO; start();
        push(1'b1, 1'b0, base, 4'h0);
        push_data(base, 2, 0);
        wait_idle();
        check_burst(base, 2, "R9 late claim");
        chk(ab_cnt == ab_base, "R9 no abort at limit", ab_cnt - ab_base, 0);

        // R8: no claim, full queue, then partly filled queue
        for (int g = 0; g <= 4; g += 4) begin
            base = 32'h6000_0000 + 32'(g * 64); dsel_dly = TMO + 1; start();
            push(1'b1, 1'b0, base, 4'h0);
            push_data(base, 3, g);
            wait_idle();
            chk(ab_cnt - ab_base == 1, "R8 one abort pulse", ab_cnt - ab_base, 1);
            chk(lg_n == log_base, "R8 nothing transferred", lg_n - log_base, 0);
            chk(fifo_empty && req_n && !mst_oe, "R8 burst discarded",
                {fifo_empty, req_n, mst_oe}, 3'b110);
            base = base + 32'h100; dsel_dly = 1; start();
            push(1'b1, 1'b0, base, 4'h0);
            push_data(base, 2, 0);
            wait_idle();
            check_burst(base, 2, "R8 next burst");
        end

        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        report();
    end
endmodule